// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block turns a module clock and a packed 16-bit timing word into the bit timing that a CAN controller needs. A programmable prescaler divides the clock into time quanta. Each bit then runs through three segments: a one-quantum synchronization segment, a first phase segment (propagation time plus phase buffer 1) and a second phase segment. The receive line is sampled once per bit, at the point where the first phase segment ends. The block reports that point with a one-cycle `sample_stb` and the captured value on `rx_bit`. The end of every bit is reported with a one-cycle `bit_stb`.

After reset the unit is idle and produces no strobes. It starts when it sees a recessive-to-dominant edge on `rx` while the bus is idle and hard synchronization is enabled. That edge starts a new bit at the synchronization segment. While bits are running, a falling edge outside the synchronization segment counts as a phase error. The block corrects it by stretching the first phase segment or by trimming the second, never by more than the jump width, and it makes at most one such correction between two sample points. A new timing word is picked up only at a bit boundary or at a hard synchronization.

Frame decoding, bit stuffing, error handling and the transmit path belong to the surrounding controller.

Top module: `can_bit_timer`

## Requirements
- R1: The timing word is split into five fields. Bit 15 is reserved and has no effect. Bits 14:12 hold the phase-2 length minus one. Bits 11:8 hold the phase-1 length minus one, where phase 1 includes the propagation time. Bits 7:6 hold the jump width minus one. Bits 5:0 hold the prescaler minus one. One quantum lasts prescaler clock cycles, and a bit lasts 1 + phase-1 + phase-2 quanta.
- R2: `sample_stb` is high for exactly one cycle per bit, at the end of phase 1. With no correction, this is prescaler x (1 + phase-1) cycles after the clock edge that detected the starting edge. At that same edge `rx_bit` takes the value of `rx`.
- R3: `bit_stb` is high for exactly one cycle at the end of each bit. It is never high in the same cycle as `sample_stb`. With no correction, consecutive bit ends are prescaler x (1 + phase-1 + phase-2) cycles apart.
- R4: Reset leaves `sample_stb` and `bit_stb` low, `rx_bit` at 1 and the unit idle. While idle, a falling edge produces no strobes unless `hsync_en` and `bus_idle` are both 1.
- R5: A falling edge on `rx` seen while `bus_idle` and `hsync_en` are both 1 restarts the bit at the synchronization segment, with the prescaler cleared.
- R6: A falling edge seen during quantum k of phase 1 (k counted from 0) lengthens phase 1 by min(k + 1, jump width) quanta.
- R7: A falling edge seen during quantum k of a phase 2 of length L trims phase 2 by the jump width when L - k exceeds the jump width. Otherwise the bit ends in that cycle, `bit_stb` is raised, and the next bit starts at once.
- R8: After one phase correction, further edges have no effect until the next sample point.
- R9: A change of the timing word takes effect only from the next bit boundary. The bit in progress keeps its old timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_word | input | 16 | Packed timing word (fields in R1) |
| rx | input | 1 | Receive line, already synchronized to clk; 1 = recessive |
| bus_idle | input | 1 | Bus is idle, so a falling edge is a hard synchronization |
| hsync_en | input | 1 | Allows hard synchronization |
| rx_bit | output | 1 | Bus value captured at the last sample point |
| sample_stb | output | 1 | One-cycle strobe at the sample point |
| bit_stb | output | 1 | One-cycle strobe at each bit end |

## Verification
Any error in the quantum counter, a segment length or the latched timing word moves `sample_stb` or `bit_stb` off its expected cycle, so it shows at the ports within the bit where it occurs. A correction that is wrongly sized or wrongly allowed shows at the very next sample point, which comes one or more quanta early or late. A timing word latched at the wrong moment shows on the first strobe after the word changes. Each scenario therefore measures the cycle offsets of the strobes from the synchronizing edge, including the edges that fall inside each segment.

// File: rtl/can_bt_pkg.sv
// Package: shared field layout, widths and types for the bit timing unit.
// Assumes the 16-bit word layout of R1; every width below derives from it.
package can_bt_pkg;

    localparam int CFG_W   = 16;
    localparam int BRP_W   = 6;
    localparam int SJW_W   = 2;
    localparam int S1_W    = 4;
    localparam int S2_W    = 3;
    localparam int BRP_LSB = 0;
    localparam int SJW_LSB = BRP_LSB + BRP_W;
    localparam int S1_LSB  = SJW_LSB + SJW_W;
    localparam int S2_LSB  = S1_LSB + S1_W;
    // Segment lengths up to phase-1 max plus jump width need one extra bit of headroom.
    localparam int QLEN_W  = S1_W + 2;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_ONE  = 2'd1,
        SEG_TWO  = 2'd2
    } seg_e;

    typedef struct packed {
        logic [BRP_W:0]    brp;
        logic [SJW_W:0]    sjw;
        logic [QLEN_W-1:0] seg1;
        logic [QLEN_W-1:0] seg2;
    } bt_cfg_t;

    // Turns the packed word into lengths (field plus one); the reserved bit is ignored.
    function automatic bt_cfg_t bt_decode(input logic [CFG_W-1:0] w);
        bt_cfg_t d;
        d.brp  = (BRP_W+1)'(w[BRP_LSB +: BRP_W]) + (BRP_W+1)'(1);
        d.sjw  = (SJW_W+1)'(w[SJW_LSB +: SJW_W]) + (SJW_W+1)'(1);
        d.seg1 = QLEN_W'(w[S1_LSB +: S1_W]) + QLEN_W'(1);
        d.seg2 = QLEN_W'(w[S2_LSB +: S2_W]) + QLEN_W'(1);
        return d;
    endfunction

endpackage

// File: rtl/can_bt_edge.sv
// Edge detector: flags a recessive-to-dominant transition of rx.
// Assumes rx is already synchronized to clk. The held value resets to recessive.
module can_bt_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic rx,
    output logic fall
);

    logic rx_q;

    // Hold the previous line value.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= 1'b1;
        else        rx_q <= rx;
    end

    assign fall = rx_q & ~rx;

endmodule

// File: rtl/can_bt_prescaler.sv
// Quantum prescaler: raises tq_end in the last clock cycle of every quantum.
// Assumes brp_len is 1 or more. It holds at zero while idle and clears on restart.
module can_bt_prescaler #(
    parameter int PC_W = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          restart,
    input  logic [PC_W:0] brp_len,
    output logic          tq_end
);

    logic [PC_W-1:0] pc_q;

    assign tq_end = run && ({1'b0, pc_q} == brp_len - (PC_W+1)'(1));

    // Count clock cycles within the current quantum.
    always_ff @(posedge clk) begin
        if (!rst_n)                          pc_q <= '0;
        else if (restart || !run || tq_end)  pc_q <= '0;
        else                                 pc_q <= pc_q + PC_W'(1);
    end

endmodule

// File: rtl/can_bt_seq.sv
// Segment sequencer: steps each bit through the sync, phase 1 and phase 2 segments.
// It applies hard synchronization and jump-width-limited phase correction.
// It latches the timing word at bit ends and raises the sample and bit strobes.
// Assumes tq_end comes from a prescaler driven by brp_len and restart.
module can_bt_seq
    import can_bt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              rx,
    input  logic              fall,
    input  logic              bus_idle,
    input  logic              hsync_en,
    input  logic              tq_end,
    output logic              run,
    output logic              restart,
    output logic [BRP_W:0]    brp_len,
    output seg_e              seg,
    output logic [QLEN_W-1:0] qc,
    output logic              rx_bit,
    output logic              sample_stb,
    output logic              bit_stb
);

    bt_cfg_t           cfg_new;
    bt_cfg_t           cfg_q;
    seg_e              seg_q;
    logic [QLEN_W-1:0] qc_q;
    logic [QLEN_W-1:0] seg1_q;
    logic [QLEN_W-1:0] seg2_q;
    logic              run_q;
    logic              used_q;

    logic              hard;
    logic              resync;
    logic              in1;
    logic              in2;
    logic [QLEN_W-1:0] sjw_ext;
    logic [QLEN_W-1:0] err1;
    logic [QLEN_W-1:0] rem2;
    logic              cut;
    logic [QLEN_W-1:0] len1;
    logic [QLEN_W-1:0] len2;
    logic              last1;
    logic              last2;

    assign cfg_new = bt_decode(cfg_word);
    assign sjw_ext = QLEN_W'(cfg_q.sjw);
    assign in1     = (seg_q == SEG_ONE);
    assign in2     = (seg_q == SEG_TWO);
    assign hard    = fall && hsync_en && bus_idle;
    assign resync  = run_q && fall && !hard && !used_q;

    // Work out the phase error and the segment lengths after any correction.
    always_comb begin
        err1  = qc_q + QLEN_W'(1);
        rem2  = seg2_q - qc_q;
        cut   = resync && in2 && (rem2 <= sjw_ext);
        len1  = seg1_q;
        len2  = seg2_q;
        if (resync && in1)
            len1 = seg1_q + ((err1 < sjw_ext) ? err1 : sjw_ext);
        if (resync && in2 && !cut)
            len2 = seg2_q - sjw_ext;
        last1 = tq_end && in1 && (qc_q == len1 - QLEN_W'(1));
        last2 = tq_end && in2 && (qc_q == len2 - QLEN_W'(1));
    end

    assign restart = hard || cut;

    // Advance the segment state, apply corrections, latch the timing word and raise the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q      <= 1'b0;
            seg_q      <= SEG_SYNC;
            qc_q       <= '0;
            cfg_q      <= bt_decode('0);
            seg1_q     <= QLEN_W'(1);
            seg2_q     <= QLEN_W'(1);
            used_q     <= 1'b0;
            rx_bit     <= 1'b1;
            sample_stb <= 1'b0;
            bit_stb    <= 1'b0;
        end else begin
            sample_stb <= 1'b0;
            bit_stb    <= 1'b0;
            if (hard) begin
                run_q  <= 1'b1;
                seg_q  <= SEG_SYNC;
                qc_q   <= '0;
                cfg_q  <= cfg_new;
                seg1_q <= cfg_new.seg1;
                seg2_q <= cfg_new.seg2;
                used_q <= 1'b0;
            end else if (cut) begin
                seg_q   <= SEG_SYNC;
                qc_q    <= '0;
                cfg_q   <= cfg_new;
                seg1_q  <= cfg_new.seg1;
                seg2_q  <= cfg_new.seg2;
                used_q  <= 1'b1;
                bit_stb <= 1'b1;
            end else if (run_q) begin
                if (resync && (in1 || in2))
                    used_q <= 1'b1;
                seg1_q <= len1;
                seg2_q <= len2;
                if (tq_end) begin
                    unique case (seg_q)
                        SEG_SYNC: begin
                            seg_q <= SEG_ONE;
                            qc_q  <= '0;
                        end
                        SEG_ONE: begin
                            if (last1) begin
                                seg_q      <= SEG_TWO;
                                qc_q       <= '0;
                                sample_stb <= 1'b1;
                                rx_bit     <= rx;
                                used_q     <= 1'b0;
                            end else begin
                                qc_q <= qc_q + QLEN_W'(1);
                            end
                        end
                        SEG_TWO: begin
                            if (last2) begin
                                seg_q   <= SEG_SYNC;
                                qc_q    <= '0;
                                bit_stb <= 1'b1;
                                cfg_q   <= cfg_new;
                                seg1_q  <= cfg_new.seg1;
                                seg2_q  <= cfg_new.seg2;
                            end else begin
                                qc_q <= qc_q + QLEN_W'(1);
                            end
                        end
                        default: seg_q <= SEG_SYNC;
                    endcase
                end
            end
        end
    end

    assign run     = run_q;
    assign brp_len = cfg_q.brp;
    assign seg     = seg_q;
    assign qc      = qc_q;

endmodule

// File: rtl/can_bit_timer.sv
// Top of the CAN bit timing unit. It wires the edge detector, the quantum
// prescaler and the segment sequencer together.
// Assumes rx is synchronous to clk and that reset is held for at least one clock.
module can_bit_timer
    import can_bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             rx,
    input  logic             bus_idle,
    input  logic             hsync_en,
    output logic             rx_bit,
    output logic             sample_stb,
    output logic             bit_stb
);

    logic              fall_w;
    logic              run_w;
    logic              restart_w;
    logic              tq_end_w;
    logic [BRP_W:0]    brp_w;
    seg_e              seg_w;
    logic [QLEN_W-1:0] qc_w;

    can_bt_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .rx    (rx),
        .fall  (fall_w)
    );

    can_bt_prescaler #(.PC_W(BRP_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_w),
        .restart (restart_w),
        .brp_len (brp_w),
        .tq_end  (tq_end_w)
    );

    can_bt_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_word   (cfg_word),
        .rx         (rx),
        .fall       (fall_w),
        .bus_idle   (bus_idle),
        .hsync_en   (hsync_en),
        .tq_end     (tq_end_w),
        .run        (run_w),
        .restart    (restart_w),
        .brp_len    (brp_w),
        .seg        (seg_w),
        .qc         (qc_w),
        .rx_bit     (rx_bit),
        .sample_stb (sample_stb),
        .bit_stb    (bit_stb)
    );

endmodule

// File: rtl/can_bt_checker.sv
// Checker for the bit timing unit. It holds properties on strobe shape, the
// captured value, idle quietness and hard synchronization. It is bound to the top.
module can_bt_checker
    import can_bt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rx,
    input logic              fall,
    input logic              hsync_en,
    input logic              bus_idle,
    input logic              run,
    input logic              tq_end,
    input seg_e              seg,
    input logic [QLEN_W-1:0] qc,
    input logic              rx_bit,
    input logic              sample_stb,
    input logic              bit_stb
);

    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && bit_stb));

    p_sample_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);

    p_bit_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> !bit_stb);

    p_sample_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sample_stb) |-> (rx_bit == $past(rx)));

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tq_end);

    p_hard_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && hsync_en && bus_idle) |=> (run && seg == SEG_SYNC && qc == '0));

endmodule

bind can_bit_timer can_bt_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx         (rx),
    .fall       (fall_w),
    .hsync_en   (hsync_en),
    .bus_idle   (bus_idle),
    .run        (run_w),
    .tq_end     (tq_end_w),
    .seg        (seg_w),
    .qc         (qc_w),
    .rx_bit     (rx_bit),
    .sample_stb (sample_stb),
    .bit_stb    (bit_stb)
);

// File: tb/test_can_bit_timer.sv
// Bench for can_bit_timer. A vector table checks field decoding and nominal
// timing; directed tests then cover reset, corrections and timing word changes.
module test_can_bit_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_word = 16'h0000;
    logic        rx = 1'b1;
    logic        bus_idle = 1'b1;
    logic        hsync_en = 1'b1;
    logic        rx_bit;
    logic        sample_stb;
    logic        bit_stb;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int t0 = 0;
    int s_q[$];
    int b_q[$];
    int v_q[$];

    // Table entries: {timing word, sample offset, bit end offset} in cycles from the detecting edge.
    localparam logic [47:0] VECS [6] = '{
        48'h34C1_000C_0014,
        48'h1600_0008_000A,
        48'h0000_0002_0003,
        48'hB4C1_000C_0014,
        48'h5341_000A_0016,
        48'h7FFF_0440_0640
    };

    can_bit_timer i_can_bit_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_word   (cfg_word),
        .rx         (rx),
        .bus_idle   (bus_idle),
        .hsync_en   (hsync_en),
        .rx_bit     (rx_bit),
        .sample_stb (sample_stb),
        .bit_stb    (bit_stb)
    );

    always #2 clk = ~clk;

    // Absolute cycle count.
    always @(posedge clk) cyc <= cyc + 1;

    // Log strobe cycles away from the active edge.
    always @(negedge clk) begin
        if (sample_stb) begin
            s_q.push_back(cyc);
            v_q.push_back(int'(rx_bit));
        end
        if (bit_stb) b_q.push_back(cyc);
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Offset of the n-th logged event after t0, or -1 if there is none.
    function automatic int nth(input int q[$], input int base, input int n);
        int k = 0;
        foreach (q[i]) begin
            if (q[i] > base) begin
                k++;
                if (k == n) return q[i] - base;
            end
        end
        return -1;
    endfunction

    // rx_bit value logged at the n-th sample after t0.
    function automatic int nth_val(input int n);
        int k = 0;
        foreach (s_q[i]) begin
            if (s_q[i] > t0) begin
                k++;
                if (k == n) return v_q[i];
            end
        end
        return -1;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rx = 1'b1; bus_idle = 1'b1; hsync_en = 1'b1;
        repeat (3) @(negedge clk);
        s_q.delete(); b_q.delete(); v_q.delete();
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Drive a falling edge and set t0 to the cycle of the edge that detects it.
    task automatic hard_sync();
        rx = 1'b0;
        @(negedge clk);
        t0 = cyc;
        bus_idle = 1'b0;
    endtask

    task automatic wait_rel(input int n);
        while (cyc < t0 + n) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Vector walk: R1 decode and quantum length, R2 sample point, R3 bit period, R5 start.
        foreach (VECS[i]) begin
            do_reset();
            cfg_word = VECS[i][47:32];
            @(negedge clk);
            hard_sync();
            wait_rel(2 * int'(VECS[i][15:0]) + 3);
            chk("R1/R2 sample offset", nth(s_q, t0, 1), int'(VECS[i][31:16]));
            chk("R5 first bit end", nth(b_q, t0, 1), int'(VECS[i][15:0]));
            chk("R3 bit period", nth(b_q, t0, 2), 2 * int'(VECS[i][15:0]));
            chk("R2 rx_bit dominant", nth_val(1), 0);
        end

        // R4: reset values.
        do_reset();
        chk("R4 sample_stb at reset", int'(sample_stb), 0);
        chk("R4 bit_stb at reset", int'(bit_stb), 0);
        chk("R4 rx_bit at reset", int'(rx_bit), 1);
        // R4: an edge with hard sync disabled, then with the bus busy, starts nothing.
        cfg_word = 16'h34C1;
        hsync_en = 1'b0;
        rx = 1'b0;
        repeat (60) @(negedge clk);
        rx = 1'b1;
        hsync_en = 1'b1;
        bus_idle = 1'b0;
        @(negedge clk);
        rx = 1'b0;
        repeat (60) @(negedge clk);
        chk("R4 no strobes while idle", s_q.size() + b_q.size(), 0);

        // R6: edge in phase-1 quantum 1 adds 2 quanta (word 0x34C1: prescaler 2, 1+5+4, jump 4).
        do_reset();
        cfg_word = 16'h34C1;
        @(negedge clk);
        hard_sync();
        wait_rel(14); rx = 1'b1;
        wait_rel(24); rx = 1'b0;
        wait_rel(50);
        chk("R6 lengthened sample", nth(s_q, t0, 2), 36);
        chk("R6 lengthened bit end", nth(b_q, t0, 2), 44);

        // R6: edge in quantum 4 is capped at jump width 4.
        do_reset();
        cfg_word = 16'h34C1;
        @(negedge clk);
        hard_sync();
        wait_rel(14); rx = 1'b1;
        wait_rel(30); rx = 1'b0;
        wait_rel(52);
        chk("R6 capped sample", nth(s_q, t0, 2), 40);

        // R8: second edge before the sample point is ignored.
        do_reset();
        cfg_word = 16'h34C1;
        @(negedge clk);
        hard_sync();
        wait_rel(14); rx = 1'b1;
        wait_rel(24); rx = 1'b0;
        wait_rel(26); rx = 1'b1;
        wait_rel(28); rx = 1'b0;
        wait_rel(50);
        chk("R8 single correction", nth(s_q, t0, 2), 36);

        // R7: partial trim (word 0x5341: prescaler 2, 1+4+6, jump 2), edge in phase-2 quantum 1.
        do_reset();
        cfg_word = 16'h5341;
        @(negedge clk);
        hard_sync();
        wait_rel(4);  rx = 1'b1;
        wait_rel(12); rx = 1'b0;
        wait_rel(34);
        chk("R7 trimmed bit end", nth(b_q, t0, 1), 18);
        chk("R7 next sample", nth(s_q, t0, 2), 28);

        // R7: remaining phase 2 within jump width ends the bit at once.
        do_reset();
        cfg_word = 16'h34C1;
        @(negedge clk);
        hard_sync();
        wait_rel(4);  rx = 1'b1;
        wait_rel(16); rx = 1'b0;
        wait_rel(34);
        chk("R7 immediate bit end", nth(b_q, t0, 1), 17);
        chk("R7 sample after cut", nth(s_q, t0, 2), 29);

        // R9: word changed mid-bit to 0x1600 (prescaler 1, 1+7+2) only applies from the next bit.
        do_reset();
        cfg_word = 16'h34C1;
        @(negedge clk);
        hard_sync();
        wait_rel(5); rx = 1'b1; cfg_word = 16'h1600;
        wait_rel(34);
        chk("R9 first sample old timing", nth(s_q, t0, 1), 12);
        chk("R2 rx_bit recessive", nth_val(1), 1);
        chk("R9 first bit end old timing", nth(b_q, t0, 1), 20);
        chk("R9 second sample new timing", nth(s_q, t0, 2), 28);
        chk("R9 second bit end new timing", nth(b_q, t0, 2), 30);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule